// File: doc/BRIEF.md
# Deferred-Fault Poison Tracker

This block keeps one poison flag for each general register so that loads can be issued speculatively without trapping. When a speculative load would fault, it does not raise an exception. It marks its destination register as poisoned instead. Ordinary operations give their destination the OR of their source flags, so the poison follows every dependence chain. Software therefore needs only one check, on the last register of a chain.

The pipeline drives a writeback port with the destination index, two source indices, an operation kind and a fault flag. A separate clear port wipes a register's flag when a non-speculative value lands in it. A check port names one register. One cycle later the block returns an acknowledge, together with a redirect flag that tells the front end whether to jump to recovery code.

Top module: `poison_tracker`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `chk_ack` is low. After reset every register's flag reads clean.
- R2: A writeback with kind 2 (speculative load) sets the destination flag to `wb_fault` OR the flag of `wb_src_a`, the address base.
- R3: A writeback with kind 0 (operation) sets the destination flag to the OR of the flags of `wb_src_a` and `wb_src_b`. Sources are read as they stood before this cycle's update.
- R4: A writeback with kind 1 (non-speculative load) clears the destination flag, whatever the sources and fault input hold.
- R5: A writeback with kind 3 is reserved and leaves every flag unchanged.
- R6: `clr_valid` clears the flag of `clr_idx`. If a writeback targets the same register in the same cycle, the writeback value wins.
- R7: Register 0 always reads clean. Writebacks and clears aimed at it have no effect.
- R8: `chk_ack` rises in the cycle after `chk_valid`. `chk_redirect` then equals the flag of `chk_idx` including any update made in the same cycle as the check.
- R9: Poison set by a faulting speculative load passes through a chain of several dependent operations, so a check on the final register alone redirects.
- R10: A writeback with `wb_valid` low changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_valid | input | 1 | Writeback present |
| wb_kind | input | 2 | 0 op, 1 load, 2 speculative load, 3 reserved |
| wb_dst | input | IDX_W | Destination register |
| wb_src_a | input | IDX_W | First source (address base for loads) |
| wb_src_b | input | IDX_W | Second source |
| wb_fault | input | 1 | Speculative load would have faulted |
| clr_valid | input | 1 | Non-speculative write clears a flag |
| clr_idx | input | IDX_W | Register to clear |
| chk_valid | input | 1 | Check request |
| chk_idx | input | IDX_W | Register to check |
| chk_ack | output | 1 | Check answered (registered) |
| chk_redirect | output | 1 | Checked register is poisoned (registered) |

## Verification
A writeback or clear applied in cycle k changes the stored flag at the edge that ends cycle k. A check issued in cycle k is answered on `chk_ack`/`chk_redirect` right after that same edge, and the answer already reflects the cycle-k update. The bench drives inputs at the falling edge. For each check it queues the expected flag, computed from its own flag model with the same-cycle update applied. A monitor samples 2 ns after each rising edge and pops one entry per acknowledge. Any acknowledge with no queued entry is a failure, and so is any entry left in the queue at the end.

// File: rtl/poison_pkg.sv
package poison_pkg;
  typedef enum logic [1:0] {
    K_OP   = 2'd0,
    K_LOAD = 2'd1,
    K_SPEC = 2'd2,
    K_RSVD = 2'd3
  } wb_kind_e;
endpackage

// File: rtl/poison_calc.sv
module poison_calc
  import poison_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] kind,
  input  logic       fault,
  input  logic       src_a_bit,
  input  logic       src_b_bit,
  output logic       wr_en,
  output logic       wr_bit
);
  always_comb begin
    wr_en  = 1'b0;
    wr_bit = 1'b0;
    if (valid) begin
      case (wb_kind_e'(kind))
        K_OP:   begin wr_en = 1'b1; wr_bit = src_a_bit | src_b_bit; end
        K_LOAD: begin wr_en = 1'b1; wr_bit = 1'b0; end
        K_SPEC: begin wr_en = 1'b1; wr_bit = fault | src_a_bit; end
        default: begin wr_en = 1'b0; wr_bit = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/poison_store.sv
module poison_store #(
  parameter int NUM_REGS = 128,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_a_idx,
  input  logic [IDX_W-1:0] rd_b_idx,
  input  logic [IDX_W-1:0] rd_n_idx,
  output logic             rd_a,
  output logic             rd_b,
  output logic             rd_next
);
  logic [NUM_REGS-1:0] bits_q;
  logic [NUM_REGS-1:0] bits_d;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flag
    if (g == 0) begin : g_zero
      assign bits_d[g] = 1'b0;
    end else begin : g_live
      assign bits_d[g] = (wr_en && wr_idx == IDX_W'(g)) ? wr_bit :
                         (clr_en && clr_idx == IDX_W'(g)) ? 1'b0 : bits_q[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bits_q <= '0;
    else     bits_q <= bits_d;
  end

  assign rd_a    = bits_q[rd_a_idx];
  assign rd_b    = bits_q[rd_b_idx];
  assign rd_next = bits_d[rd_n_idx];
endmodule

// File: rtl/poison_check.sv
module poison_check (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic flag_next,
  output logic ack,
  output logic redirect
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ack      <= 1'b0;
      redirect <= 1'b0;
    end else begin
      ack      <= req;
      redirect <= req & flag_next;
    end
  end
endmodule

// File: rtl/poison_tracker.sv
module poison_tracker #(
  parameter int NUM_REGS = 128,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wb_valid,
  input  logic [1:0]       wb_kind,
  input  logic [IDX_W-1:0] wb_dst,
  input  logic [IDX_W-1:0] wb_src_a,
  input  logic [IDX_W-1:0] wb_src_b,
  input  logic             wb_fault,
  input  logic             clr_valid,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             chk_valid,
  input  logic [IDX_W-1:0] chk_idx,
  output logic             chk_ack,
  output logic             chk_redirect
);
  logic src_a_bit, src_b_bit, wr_en, wr_bit, flag_next;

  poison_calc u_calc (
    .valid(wb_valid), .kind(wb_kind), .fault(wb_fault),
    .src_a_bit(src_a_bit), .src_b_bit(src_b_bit),
    .wr_en(wr_en), .wr_bit(wr_bit)
  );

  poison_store #(.NUM_REGS(NUM_REGS)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wb_dst), .wr_bit(wr_bit),
    .clr_en(clr_valid), .clr_idx(clr_idx),
    .rd_a_idx(wb_src_a), .rd_b_idx(wb_src_b), .rd_n_idx(chk_idx),
    .rd_a(src_a_bit), .rd_b(src_b_bit), .rd_next(flag_next)
  );

  poison_check u_check (
    .clk(clk), .rst(rst), .req(chk_valid), .flag_next(flag_next),
    .ack(chk_ack), .redirect(chk_redirect)
  );
endmodule

// File: rtl/poison_tracker_chk.sv
module poison_tracker_chk #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             wb_valid,
  input logic [1:0]       wb_kind,
  input logic [IDX_W-1:0] wb_dst,
  input logic             wb_fault,
  input logic             clr_valid,
  input logic [IDX_W-1:0] clr_idx,
  input logic             chk_valid,
  input logic [IDX_W-1:0] chk_idx,
  input logic             chk_ack,
  input logic             chk_redirect
);
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> !chk_ack);

  a_r8_ack_follows_req: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> chk_ack);

  a_r8_no_spurious_ack: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !chk_ack);

  a_r8_redirect_has_ack: assert property (@(posedge clk) disable iff (rst)
    chk_redirect |-> chk_ack);

  a_r7_zero_clean: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_idx == '0) |=> !chk_redirect);

  a_r2_fault_bypass: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_kind == 2'd2 && wb_fault && wb_dst != '0 &&
     chk_valid && chk_idx == wb_dst) |=> chk_redirect);

  a_r4_load_clears: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_kind == 2'd1 && chk_valid && chk_idx == wb_dst) |=> !chk_redirect);

  a_r6_clear_bypass: assert property (@(posedge clk) disable iff (rst)
    (clr_valid && chk_valid && chk_idx == clr_idx &&
     !(wb_valid && wb_dst == clr_idx)) |=> !chk_redirect);
endmodule

bind poison_tracker poison_tracker_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .wb_valid(wb_valid), .wb_kind(wb_kind),
  .wb_dst(wb_dst), .wb_fault(wb_fault), .clr_valid(clr_valid),
  .clr_idx(clr_idx), .chk_valid(chk_valid), .chk_idx(chk_idx),
  .chk_ack(chk_ack), .chk_redirect(chk_redirect)
);

// File: tb/poison_tracker_test.sv
`timescale 1ns/1ps
module poison_tracker_test;
  localparam int N = 128;
  localparam int W = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wb_valid = 1'b0, wb_fault = 1'b0, clr_valid = 1'b0, chk_valid = 1'b0;
  logic [1:0] wb_kind = 2'd0;
  logic [W-1:0] wb_dst = '0, wb_src_a = '0, wb_src_b = '0, clr_idx = '0, chk_idx = '0;
  logic chk_ack, chk_redirect;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  logic model [N];
  bit exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  poison_tracker #(.NUM_REGS(N)) uut (
    .clk(clk), .rst(rst), .wb_valid(wb_valid), .wb_kind(wb_kind),
    .wb_dst(wb_dst), .wb_src_a(wb_src_a), .wb_src_b(wb_src_b),
    .wb_fault(wb_fault), .clr_valid(clr_valid), .clr_idx(clr_idx),
    .chk_valid(chk_valid), .chk_idx(chk_idx),
    .chk_ack(chk_ack), .chk_redirect(chk_redirect)
  );

  task automatic cyc(input bit wv, input int kind, input int dst, input int a,
                     input int b, input bit fault, input bit cv, input int cidx,
                     input bit kv, input int kidx, input string tag);
    logic nxt [N];
    @(negedge clk);
    wb_valid = wv; wb_kind = 2'(kind); wb_dst = W'(dst); wb_src_a = W'(a);
    wb_src_b = W'(b); wb_fault = fault; clr_valid = cv; clr_idx = W'(cidx);
    chk_valid = kv; chk_idx = W'(kidx);
    nxt = model;
    if (cv) nxt[cidx] = 1'b0;
    if (wv) begin
      case (kind)
        0: nxt[dst] = model[a] | model[b];
        1: nxt[dst] = 1'b0;
        2: nxt[dst] = fault | model[a];
        default: ;
      endcase
    end
    nxt[0] = 1'b0;
    if (kv) begin exp_q.push_back(nxt[kidx]); tag_q.push_back(tag); end
    model = nxt;
  endtask

  task automatic chk(input int idx, input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, idx, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (!rst && chk_ack) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R8: unexpected ack, actual redirect=%0b expected no ack", chk_redirect);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (chk_redirect !== e) begin
          mismatched++;
          $display("FAIL %s: redirect actual=%0b expected=%0b", t, chk_redirect, e);
        end
      end
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = 1'b0;
    repeat (3) @(negedge clk);
    compared++;
    if (chk_ack !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: ack in reset actual=%0b expected=0", chk_ack);
    end
    @(negedge clk); rst = 1'b0;
    compared++;
    if (chk_ack !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: ack after reset actual=%0b expected=0", chk_ack);
    end
    for (int i = 0; i < N; i++) chk(i, "R1");
    // R2 speculative load: fault, check in the same cycle (R8 bypass)
    cyc(1, 2, 5, 0, 0, 1, 0, 0, 1, 5, "R2");
    cyc(1, 2, 6, 5, 0, 0, 0, 0, 1, 6, "R2");
    cyc(1, 2, 7, 1, 0, 0, 0, 0, 0, 0, "R2");
    chk(7, "R2");
    // R3 operations
    cyc(1, 0, 8, 1, 5, 0, 0, 0, 1, 8, "R3");
    cyc(1, 0, 9, 1, 2, 1, 0, 0, 1, 9, "R3");
    cyc(1, 0, 10, 2, 6, 0, 0, 0, 0, 0, "R3");
    chk(10, "R3");
    // R9 chain
    cyc(1, 2, 20, 0, 0, 1, 0, 0, 0, 0, "R9");
    cyc(1, 0, 21, 20, 3, 0, 0, 0, 0, 0, "R9");
    cyc(1, 0, 22, 4, 21, 0, 0, 0, 0, 0, "R9");
    cyc(1, 0, 23, 22, 22, 0, 0, 0, 0, 0, "R9");
    chk(23, "R9");
    chk(4, "R9");
    // R4 load clears
    cyc(1, 1, 23, 20, 20, 1, 0, 0, 1, 23, "R4");
    chk(20, "R4");
    // R5 reserved kind
    cyc(1, 3, 5, 0, 0, 0, 0, 0, 0, 0, "R5");
    chk(5, "R5");
    cyc(1, 3, 30, 5, 5, 1, 0, 0, 0, 0, "R5");
    chk(30, "R5");
    // R10 invalid writeback
    cyc(0, 2, 31, 5, 0, 1, 0, 0, 0, 0, "R10");
    chk(31, "R10");
    // R6 clear, priority and bypass
    cyc(0, 0, 0, 0, 0, 0, 1, 5, 0, 0, "R6");
    chk(5, "R6");
    cyc(1, 2, 40, 0, 0, 1, 1, 40, 1, 40, "R6");
    cyc(0, 0, 0, 0, 0, 0, 1, 8, 1, 8, "R6");
    chk(40, "R6");
    // R7 register zero
    cyc(1, 2, 0, 0, 0, 1, 0, 0, 1, 0, "R7");
    cyc(1, 0, 0, 6, 40, 0, 0, 0, 0, 0, "R7");
    chk(0, "R7");
    // R8 update to another register while checking
    cyc(1, 2, 50, 0, 0, 1, 0, 0, 1, 6, "R8");
    chk(50, "R8");
    @(negedge clk);
    wb_valid = 0; clr_valid = 0; chk_valid = 0;
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      compared++;
      mismatched++;
      $display("FAIL R8: missing acks actual=%0d pending expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule